// File: doc/BRIEF.md
# Stop-Mode Power Control Register

This block is a small memory-mapped control and status register that sits beside a system's stop sequencer. Software writes it once after reset to pick how deep the next stop goes. With power-down enabled, a select bit chooses between a full power-down and a partial power-down. With power-down disabled, a stop keeps its state in a retained mode. The block decodes those bits into a stop-mode code that the sequencer reads.

The sequencer pulses a stop request when the system goes to sleep and a wake strobe when it comes back. The block remembers which mode was entered. Waking from either power-down mode sets a sticky recovery flag for that mode. The same event re-initialises the control bits and the write-once lock, because a real power-down ends in a reset. A waking program reads the flags to learn where it came from, then clears both flags with one write-one acknowledge bit.

Top module: `stopctl_reg`

## Requirements
- R1: After a synchronous reset, `bus_rdata` reads 0x00, `sel_mode` is 2'b00 and `asleep` is 0.
- R2: `bus_rdata` places the fields as follows: bit 4 is the full-power-down recovery flag, bit 3 is the partial-power-down recovery flag, bit 1 is the power-down enable and bit 0 is the partial/full select. Bits 7 to 5 and bit 2 always read 0.
- R3: The first bus write after reset loads the enable from `bus_wdata[1]` and the select from `bus_wdata[0]`. Any later write leaves both bits unchanged.
- R4: The first write locks the control bits even when it writes enable = 0 and select = 0.
- R5: `sel_mode` is 2'b00 (retained) when enable = 0, 2'b01 (full power-down) when enable = 1 and select = 0, and 2'b10 (partial power-down) when enable = 1 and select = 1.
- R6: A `stop_req` pulse while awake sets `asleep` on the next cycle and captures the current `sel_mode`. A `stop_req` pulse while asleep has no effect.
- R7: `wake` while asleep clears `asleep` on the next cycle. It sets bit 4 if the captured mode was full power-down and bit 3 if it was partial power-down. After a retained stop it sets neither flag.
- R8: Waking from either power-down mode clears the enable, the select and the write-once lock. The recovery flags keep their values, and the next write is accepted again.
- R9: A write with `bus_wdata[2]` = 1 clears both recovery flags in one cycle. A write with bit 2 = 0 leaves the flags unchanged.
- R10: When a flag-setting wake and an acknowledge write fall in the same cycle, the flag set by the wake reads 1 afterwards and the other flag reads 0. In that cycle the write does not load the control bits.
- R11: `wake` while awake has no effect on the register or on `asleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read value |
| stop_req | input | 1 | Stop-entry strobe from the sequencer |
| wake | input | 1 | Wakeup strobe from the sequencer |
| sel_mode | output | 2 | Decoded stop mode: 00 retained, 01 full, 10 partial |
| asleep | output | 1 | High between an accepted stop request and its wake |

## Verification
Two events can fall in the same cycle: the wake that sets a recovery flag and a bus write that acknowledges the flags or loads the control bits. A directed sequence lines up a partial-power-down wake with an acknowledge write, and the bench expects the partial flag set, the full flag cleared and the control bits left in their re-initialised state. The random phase drives writes, stop requests and wakes independently, so the same collision recurs many times. Every cycle is judged against a bench model that applies set-over-clear and re-init-over-write.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    parameter int unsigned REG_W = 8;

    localparam int unsigned POS_SEL    = 0;
    localparam int unsigned POS_EN     = 1;
    localparam int unsigned POS_ACK    = 2;
    localparam int unsigned POS_PART_F = 3;
    localparam int unsigned POS_FULL_F = 4;
    localparam int unsigned USED_BITS  = 5;

    typedef enum logic [1:0] {
        MODE_RETAIN  = 2'b00,
        MODE_FULL    = 2'b01,
        MODE_PARTIAL = 2'b10
    } stop_mode_e;

    typedef struct packed {
        logic en;
        logic sel;
    } ctrl_t;

    typedef struct packed {
        logic full;
        logic part;
    } flags_t;

    function automatic stop_mode_e decode_mode(ctrl_t c);
        if (!c.en) begin
            return MODE_RETAIN;
        end
        return c.sel ? MODE_PARTIAL : MODE_FULL;
    endfunction

endpackage

// File: rtl/stopctl_ctrl.sv
module stopctl_ctrl
    import stopctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_stb,
    input  ctrl_t wr_val,
    input  logic  reinit,
    output ctrl_t ctrl_q,
    output logic  lock_q
);

    always_ff @(posedge clk) begin
        if (rst || reinit) begin
            ctrl_q <= '0;
            lock_q <= 1'b0;
        end else if (wr_stb && !lock_q) begin
            ctrl_q <= wr_val;
            lock_q <= 1'b1;
        end
    end

endmodule

// File: rtl/stopctl_flags.sv
module stopctl_flags
    import stopctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ack,
    input  flags_t set_f,
    output flags_t flags_q
);

    flags_t keep;

    always_comb begin
        keep = ack ? flags_t'('0) : flags_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= keep | set_f;
        end
    end

endmodule

// File: rtl/stopctl_seq.sv
module stopctl_seq
    import stopctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       wake,
    input  stop_mode_e cur_mode,
    output logic       asleep_q,
    output flags_t     set_f,
    output logic       reinit
);

    stop_mode_e entered_q;
    logic       wake_ev;

    assign wake_ev = asleep_q && wake;

    always_comb begin
        set_f      = '0;
        set_f.full = wake_ev && (entered_q == MODE_FULL);
        set_f.part = wake_ev && (entered_q == MODE_PARTIAL);
        reinit     = set_f.full || set_f.part;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep_q  <= 1'b0;
            entered_q <= MODE_RETAIN;
        end else if (!asleep_q && stop_req) begin
            asleep_q  <= 1'b1;
            entered_q <= cur_mode;
        end else if (wake_ev) begin
            asleep_q  <= 1'b0;
            entered_q <= MODE_RETAIN;
        end
    end

endmodule

// File: rtl/stopctl_reg.sv
module stopctl_reg
    import stopctl_pkg::*;
#(
    parameter int unsigned DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stop_req,
    input  logic              wake,
    output logic [1:0]        sel_mode,
    output logic              asleep
);

    ctrl_t      wr_val;
    ctrl_t      ctrl_q;
    logic       lock_q;
    flags_t     flags_q;
    flags_t     set_f;
    logic       reinit;
    logic       ack;
    stop_mode_e cur_mode;

    assign wr_val.en  = bus_wdata[POS_EN];
    assign wr_val.sel = bus_wdata[POS_SEL];
    assign ack        = bus_wr && bus_wdata[POS_ACK];
    assign cur_mode   = decode_mode(ctrl_q);
    assign sel_mode   = cur_mode;

    stopctl_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (bus_wr),
        .wr_val (wr_val),
        .reinit (reinit),
        .ctrl_q (ctrl_q),
        .lock_q (lock_q)
    );

    stopctl_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .ack     (ack),
        .set_f   (set_f),
        .flags_q (flags_q)
    );

    stopctl_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .stop_req (stop_req),
        .wake     (wake),
        .cur_mode (cur_mode),
        .asleep_q (asleep),
        .set_f    (set_f),
        .reinit   (reinit)
    );

    always_comb begin
        for (int i = 0; i < int'(DATA_W); i++) begin
            bus_rdata[i] = 1'b0;
        end
        bus_rdata[POS_SEL]    = ctrl_q.sel;
        bus_rdata[POS_EN]     = ctrl_q.en;
        bus_rdata[POS_PART_F] = flags_q.part;
        bus_rdata[POS_FULL_F] = flags_q.full;
    end

endmodule

// File: rtl/stopctl_chk.sv
module stopctl_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              stop_req,
    input logic              wake,
    input logic [1:0]        sel_mode,
    input logic              asleep,
    input logic              lock_q
);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0 && sel_mode == 2'b00 && !asleep));

    p_reserved_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[7:5] == 3'b000 && bus_rdata[2] == 1'b0));

    p_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !(asleep && wake)) |=> (bus_rdata[1:0] == $past(bus_rdata[1:0])));

    p_lock_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !(asleep && wake)) |=> lock_q);

    p_mode_r5: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == (bus_rdata[1] ? (bus_rdata[0] ? 2'b10 : 2'b01) : 2'b00)));

    p_sleep_r6: assert property (@(posedge clk) disable iff (rst)
        (!asleep && stop_req) |=> asleep);

    p_wake_r7: assert property (@(posedge clk) disable iff (rst)
        (asleep && wake) |=> !asleep);

    p_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata[2] && !(asleep && wake)) |=> (bus_rdata[4:3] == 2'b00));

    p_hold_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (!(bus_wr && bus_wdata[2]) && !(asleep && wake)) |=> $stable(bus_rdata[4:3]));

    p_idle_wake_r11: assert property (@(posedge clk) disable iff (rst)
        (!asleep && wake && !stop_req) |=> !asleep);

endmodule

bind stopctl_reg stopctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .stop_req  (stop_req),
    .wake      (wake),
    .sel_mode  (sel_mode),
    .asleep    (asleep),
    .lock_q    (lock_q)
);

// File: tb/stopctl_reg_tb.sv
`timescale 1ns/1ps
module stopctl_reg_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stop_req = 1'b0;
    logic       wake = 1'b0;
    logic [1:0] sel_mode;
    logic       asleep;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model state
    bit       m_en, m_sel, m_lock, m_ff, m_pf, m_asleep;
    bit [1:0] m_ent;

    always #2.5 clk = ~clk;

    stopctl_reg u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stop_req  (stop_req),
        .wake      (wake),
        .sel_mode  (sel_mode),
        .asleep    (asleep)
    );

    function automatic bit [1:0] f_mode(bit en, bit sel);
        if (!en) return 2'b00;
        return sel ? 2'b10 : 2'b01;
    endfunction

    function automatic bit [7:0] f_read();
        return {3'b000, m_ff, m_pf, 1'b0, m_en, m_sel};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " R2 rdata"}, bus_rdata, f_read());
        check({tag, " R5 mode"}, {6'd0, sel_mode}, {6'd0, f_mode(m_en, m_sel)});
        check({tag, " R6 asleep"}, {7'd0, asleep}, {7'd0, m_asleep});
    endtask

    // called at a negedge; returns at the following negedge
    task automatic cyc(input bit r, input bit wr, input bit [7:0] wd, input bit sr, input bit wk);
        bit wev, pd, n_ff, n_pf;
        rst = r; bus_wr = wr; bus_wdata = wd; stop_req = sr; wake = wk;
        if (r) begin
            m_en = 0; m_sel = 0; m_lock = 0; m_ff = 0; m_pf = 0; m_asleep = 0; m_ent = 2'b00;
        end else begin
            wev  = m_asleep && wk;
            pd   = wev && (m_ent != 2'b00);
            n_ff = (wev && m_ent == 2'b01) || (m_ff && !(wr && wd[2]));
            n_pf = (wev && m_ent == 2'b10) || (m_pf && !(wr && wd[2]));
            m_ff = n_ff; m_pf = n_pf;
            if (!m_asleep && sr) begin
                m_asleep = 1; m_ent = f_mode(m_en, m_sel);
            end else if (wev) begin
                m_asleep = 0; m_ent = 2'b00;
            end
            if (pd) begin
                m_en = 0; m_sel = 0; m_lock = 0;
            end else if (wr && !m_lock) begin
                m_en = wd[1]; m_sel = wd[0]; m_lock = 1;
            end
        end
        @(negedge clk);
        rst = 0; bus_wr = 0; bus_wdata = 8'h00; stop_req = 0; wake = 0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        cyc(1, 0, 0, 0, 0);
        check("R1 rdata after reset", bus_rdata, 8'h00);
        check("R1 mode after reset", {6'd0, sel_mode}, 8'h00);
        check("R1 asleep after reset", {7'd0, asleep}, 8'h00);

        // write-once
        cyc(0, 1, 8'h03, 0, 0);
        check("R3 first write", bus_rdata, 8'h03);
        check("R5 partial mode", {6'd0, sel_mode}, 8'h02);
        cyc(0, 1, 8'h01, 0, 0);
        check("R3 second write ignored", bus_rdata, 8'h03);

        // zero write still locks
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 8'h00, 0, 0);
        cyc(0, 1, 8'h02, 0, 0);
        check("R4 zero write locks", bus_rdata, 8'h00);

        // full power-down round trip
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 8'h02, 0, 0);
        check("R5 full mode", {6'd0, sel_mode}, 8'h01);
        cyc(0, 0, 0, 1, 0);
        check("R6 stop entered", {7'd0, asleep}, 8'h01);
        cyc(0, 0, 0, 1, 0);
        check("R6 second stop ignored", {7'd0, asleep}, 8'h01);
        cyc(0, 0, 0, 0, 1);
        check("R7 full flag set", bus_rdata, 8'h10);
        check("R7 awake after wake", {7'd0, asleep}, 8'h00);
        cyc(0, 1, 8'h03, 0, 0);
        check("R8 lock reopened", bus_rdata, 8'h13);

        // partial power-down, wake collides with ack write
        cyc(0, 0, 0, 1, 0);
        cyc(0, 1, 8'h07, 0, 1);
        check("R10 set wins over ack", bus_rdata, 8'h08);
        cyc(0, 1, 8'h00, 0, 0);
        check("R9 ack bit clear keeps flags", bus_rdata, 8'h08);
        cyc(0, 1, 8'h04, 0, 0);
        check("R9 ack clears flags", bus_rdata, 8'h00);

        // retained stop, then idle wake
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1);
        check("R7 retained wake sets no flag", bus_rdata, 8'h00);
        cyc(0, 0, 0, 0, 1);
        check("R11 idle wake asleep", {7'd0, asleep}, 8'h00);
        check("R11 idle wake rdata", bus_rdata, 8'h00);
        check_all("R11 directed");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            bit r, wr, sr, wk;
            bit [7:0] wd;
            r  = ($urandom % 97) == 0;
            wr = ($urandom % 3) == 0;
            wd = 8'($urandom);
            sr = ($urandom % 4) == 0;
            wk = ($urandom % 4) == 0;
            cyc(r, wr, wd, sr, wk);
            check_all("R10 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule